// File: doc/BRIEF.md
# Directional Command Register Bank

This block serves the control subspace of a bus-slave opcode controller. Sixteen operation slots are selected by a four-bit address. Slots 0 to 13 are steering commands. Each command holds a twelve-bit value. Slot 14 is a fourteen-bit path-disable register, and slot 15 is a spare. When a steering command is written, the value goes out on an external data port towards a discrete register on the board. The block issues a one-cycle strobe on that register's own clock line. At the same time, the value is captured through the pad-side loopback into a sixteen-word shadow memory. Reads of a steering command return the shadow copy, not the board register.

The access sequencer outside this block supplies its state flags. Each access passes through an address phase, a setup state (`st_opc`), and a commit state (`st_opd`). `next_opd` is raised during setup. No valid/ready handshake exists, because the state flags already pace every access and the block never refuses one: it has no back-pressure, and an access completes in the cycles the sequencer gives it. The stage-0 operation flag and a deasserted subspace select both mute the block.

Top module: `dcb_top`

## Requirements
- R1: After reset, `ext_data` is 0xFFF, `ext_drive` is 0, every strobe is 0, `path_dis` is 0, `rp_err` is 0, and every shadow word reads back as 0xFFF.
- R2: During setup and commit of a write to slots 0..13 (with `ctl_sel`=1 and `stage0_op`=0), `ext_drive` is 1 and `ext_data` equals `wdata[11:0]`. At all other times `ext_drive` is 0 and `ext_data` is 0xFFF.
- R3: At the end of the commit state of a write with `ctl_sel`=1 and `stage0_op`=0 to any slot other than 14, shadow word `addr` takes `pad_in`. A later read of that slot returns the word in `rd_data[11:0]`, with `rd_data[15:12]`=0.
- R4: A write to slot n (0..13) raises `ext_strobe[n]`, and only that bit, for exactly the commit cycle. The strobe is registered from the setup cycle where `next_opd`=1. Reads raise no strobe.
- R5: A write to slot 14 stores `wdata[13:0]` into `path_dis`, where bit n disables command n's external register output (1 = disabled). A read of slot 14 returns it zero-extended. The write raises no strobe and leaves the shadow words unchanged.
- R6: A write to slot 15 drives no port and raises no strobe. Its shadow word takes the undriven pad value, so it reads back as 0xFFF.
- R7: When `stage0_op`=1 or `ctl_sel`=0, the block does not drive the port, issue a strobe, write the shadow, or update `path_dis`, and `rd_valid` is 0.
- R8: A write to slots 4..7 whose value has more than one zero bit sets `rp_err`, which stays set until reset. The value is still stored. A write with at most one zero bit, or a write to any other slot, leaves `rp_err` unchanged.
- R9: Reads leave all shadow words and `path_dis` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_sel | input | 1 | Control subspace selected |
| stage0_op | input | 1 | Stage-0 operation active (mutes the block) |
| wr | input | 1 | 1 = write access, 0 = read access |
| addr | input | 4 | Operation slot (address bits 5:2) |
| st_opc | input | 1 | Setup state flag |
| st_opd | input | 1 | Commit state flag |
| next_opd | input | 1 | Next cycle is the commit state |
| wdata | input | 16 | Bus write data |
| pad_in | input | 12 | Loopback of the external port from the pads |
| ext_data | output | 12 | External command data port |
| ext_drive | output | 1 | External port is driven |
| ext_strobe | output | 14 | Per-command external register clock pulse |
| path_dis | output | 14 | Per-command output disable bits |
| rd_data | output | 16 | Read-back data |
| rd_valid | output | 1 | Read-back data valid |
| rp_err | output | 1 | Sticky read-path multi-select error |

## Verification
The assertions assume the sequencer's legal ordering. `st_opc` and `st_opd` are never both high. `next_opd` is high only in the setup cycle, so a strobe can only land in a commit cycle, and each access holds its address, direction and data steady from the address phase through commit. The bench drives every access through a single task that steps through the address phase, setup, commit and idle on falling edges, with `pad_in` tied to `ext_data`, so every stimulus stays inside those rules. The bench sweeps all sixteen slots in both directions, together with the muting flags.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  parameter int CMD_W  = 12;
  parameter int N_OPS  = 16;
  parameter int N_CMD  = 14;
  parameter int BUS_W  = 16;
  localparam int OP_AW = $clog2(N_OPS);
  localparam int PE_OP = N_CMD;
  localparam int RP_LO = 4;
  localparam int RP_HI = 7;

  function automatic int unsigned zero_count(input logic [CMD_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < CMD_W; i++) if (!v[i]) n++;
    return n;
  endfunction
endpackage

// File: rtl/dcb_decode.sv
module dcb_decode
  import dcb_pkg::*;
(
  input  logic             ctl_sel,
  input  logic             stage0_op,
  input  logic             wr,
  input  logic [OP_AW-1:0] addr,
  output logic             mem_path,
  output logic             pe_hit,
  output logic             dir_wr,
  output logic [N_CMD-1:0] cmd_vec,
  output logic             rp_hit
);
  logic live;
  assign live     = ctl_sel && !stage0_op;
  assign pe_hit   = live && (int'(addr) == PE_OP);
  assign mem_path = live && (int'(addr) != PE_OP);
  assign dir_wr   = live && wr && (int'(addr) < N_CMD);
  assign rp_hit   = live && wr && (int'(addr) >= RP_LO) && (int'(addr) <= RP_HI);

  for (genvar g = 0; g < N_CMD; g++) begin : g_vec
    assign cmd_vec[g] = dir_wr && (int'(addr) == g);
  end
endmodule

// File: rtl/dcb_shadow.sv
module dcb_shadow
  import dcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [OP_AW-1:0] waddr,
  input  logic [CMD_W-1:0] wdat,
  output logic [CMD_W-1:0] rdat
);
  logic [CMD_W-1:0] mem [N_OPS];

  for (genvar g = 0; g < N_OPS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= '1;
      else if (we && int'(waddr) == g)   mem[g] <= wdat;
    end
  end

  assign rdat = mem[waddr];
endmodule

// File: rtl/dcb_strobe.sv
module dcb_strobe
  import dcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CMD-1:0] cmd_vec,
  input  logic             next_opd,
  input  logic             st_opd,
  output logic [N_CMD-1:0] strobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= cmd_vec & {N_CMD{next_opd}};
  end

  assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
  assert_strobe_in_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe != '0) |-> st_opd);
endmodule

// File: rtl/dcb_top.sv
module dcb_top
  import dcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_sel,
  input  logic             stage0_op,
  input  logic             wr,
  input  logic [OP_AW-1:0] addr,
  input  logic             st_opc,
  input  logic             st_opd,
  input  logic             next_opd,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CMD_W-1:0] pad_in,
  output logic [CMD_W-1:0] ext_data,
  output logic             ext_drive,
  output logic [N_CMD-1:0] ext_strobe,
  output logic [N_CMD-1:0] path_dis,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             rp_err
);
  logic             mem_path, pe_hit, dir_wr, rp_hit;
  logic [N_CMD-1:0] cmd_vec;
  logic [CMD_W-1:0] shadow_q;
  logic             shadow_we;

  dcb_decode u_dec (
    .ctl_sel(ctl_sel), .stage0_op(stage0_op), .wr(wr), .addr(addr),
    .mem_path(mem_path), .pe_hit(pe_hit), .dir_wr(dir_wr),
    .cmd_vec(cmd_vec), .rp_hit(rp_hit)
  );

  assign shadow_we = mem_path && wr && st_opd;

  dcb_shadow u_mem (
    .clk(clk), .rst_n(rst_n), .we(shadow_we), .waddr(addr),
    .wdat(pad_in), .rdat(shadow_q)
  );

  dcb_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .cmd_vec(cmd_vec), .next_opd(next_opd),
    .st_opd(st_opd), .strobe(ext_strobe)
  );

  assign ext_drive = dir_wr && (st_opc || st_opd);
  assign ext_data  = ext_drive ? wdata[CMD_W-1:0] : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   path_dis <= '0;
    else if (pe_hit && wr && st_opd) path_dis <= wdata[N_CMD-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rp_err <= 1'b0;
    else if (rp_hit && st_opd && zero_count(pad_in) > 1) rp_err <= 1'b1;
  end

  assign rd_valid = (mem_path || pe_hit) && !wr;
  always_comb begin
    rd_data = '0;
    if (rd_valid) begin
      if (pe_hit) rd_data[N_CMD-1:0] = path_dis;
      else        rd_data[CMD_W-1:0] = shadow_q;
    end
  end

  assert_drive_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ext_drive |-> (wr && ctl_sel && (st_opc || st_opd)));
  assert_muted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stage0_op || !ctl_sel) |-> (!ext_drive && !rd_valid));
  assert_pe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_sel && !stage0_op && wr && st_opd && int'(addr) == PE_OP) |=> $stable(path_dis));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rp_err |=> rp_err);
endmodule

// File: tb/dcb_top_test.sv
module dcb_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        ctl_sel = 0, stage0_op = 0, wr = 0, st_opc = 0, st_opd = 0, next_opd = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [11:0] ext_data, pad_in;
  logic        ext_drive, rd_valid, rp_err;
  logic [13:0] ext_strobe, path_dis;
  logic [15:0] rd_data;

  assign pad_in = ext_data;

  dcb_top uut (
    .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .stage0_op(stage0_op), .wr(wr),
    .addr(addr), .st_opc(st_opc), .st_opd(st_opd), .next_opd(next_opd),
    .wdata(wdata), .pad_in(pad_in), .ext_data(ext_data), .ext_drive(ext_drive),
    .ext_strobe(ext_strobe), .path_dis(path_dis), .rd_data(rd_data),
    .rd_valid(rd_valid), .rp_err(rp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [11:0] m_mem [16];
  logic [13:0] m_pe;
  logic        m_err;
  bit          done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int zc(input logic [11:0] v);
    int n = 0;
    for (int i = 0; i < 12; i++) if (!v[i]) n++;
    return n;
  endfunction

  task automatic access(input bit w, input int a, input logic [15:0] d,
                        input bit sel, input bit s0);
    bit live, drv;
    live = sel && !s0;
    drv  = live && w && a < 14;
    @(negedge clk);
    ctl_sel = sel; stage0_op = s0; wr = w; addr = a[3:0]; wdata = d;
    @(negedge clk);
    st_opc = 1; next_opd = 1; #1;
    chk("R2 drive", {31'd0, ext_drive}, {31'd0, drv});
    chk("R2 data", {20'd0, ext_data}, {20'd0, drv ? d[11:0] : 12'hFFF});
    @(negedge clk);
    st_opc = 0; next_opd = 0; st_opd = 1; #1;
    chk("R4 strobe", {18'd0, ext_strobe}, {18'd0, drv ? 14'(1 << a) : 14'd0});
    chk("R7 rd_valid", {31'd0, rd_valid}, {31'd0, live && !w});
    if (live && !w)
      chk(a == 14 ? "R5 read" : "R3 read", {16'd0, rd_data},
          {16'd0, a == 14 ? {2'b0, m_pe} : {4'b0, m_mem[a]}});
    @(negedge clk);
    st_opd = 0; ctl_sel = 0; wr = 0; #1;
    chk("R4 strobe end", {18'd0, ext_strobe}, 32'd0);
    if (live && w) begin
      if (a == 14) m_pe = d[13:0];
      else begin
        m_mem[a] = drv ? d[11:0] : 12'hFFF;
        if (a >= 4 && a <= 7 && zc(d[11:0]) > 1) m_err = 1;
      end
    end
    chk("R8 err", {31'd0, rp_err}, {31'd0, m_err});
    chk("R5 path_dis", {18'd0, path_dis}, {18'd0, m_pe});
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 16; a++) access(0, a, 16'h0, 1, 0);
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 12'hFFF;
    m_pe = 0; m_err = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ext_data", {20'd0, ext_data}, 32'hFFF);
    chk("R1 drive", {31'd0, ext_drive}, 0);
    chk("R1 strobe", {18'd0, ext_strobe}, 0);
    chk("R1 path_dis", {18'd0, path_dis}, 0);
    chk("R1 err", {31'd0, rp_err}, 0);
    rst_n = 1;
    read_all("R1 reset contents");
    // R3 R4 R6 R8: first sweep, read-path slots get exactly one zero
    for (int a = 0; a < 16; a++) begin
      logic [15:0] v;
      if (a >= 4 && a <= 7) v = 16'hF000 | (~(16'd1 << (a + 3)) & 16'h0FFF);
      else v = 16'((a * 16'h2A5 + 16'h13) ^ 16'hA000);
      if (a != 14) access(1, a, v, 1, 0);
    end
    read_all("R3 sweep1");
    // R9: reads changed nothing
    read_all("R9 reread");
    // R5 path disable
    access(1, 14, 16'hD5A3, 1, 0);
    access(0, 14, 16'h0, 1, 0);
    read_all("R5 no shadow change");
    // second sweep with inverted-style patterns, ops 4..7 with one zero (bit 0)
    for (int a = 0; a < 14; a++)
      access(1, a, (a >= 4 && a <= 7) ? 16'h0FFE : 16'(~(a * 16'h111)), 1, 0);
    read_all("R3 sweep2");
    // R7 muting
    for (int a = 0; a < 16; a++) begin
      access(1, a, 16'h0000, 1, 1);
      access(1, a, 16'h0000, 0, 0);
      access(0, a, 16'h0000, 1, 1);
    end
    read_all("R7 unchanged");
    // R8 error: op 9 with many zeros does not set; op 5 with two zeros does
    access(1, 9, 16'h0000, 1, 0);
    access(1, 5, 16'h0FFC, 1, 0);
    access(0, 5, 16'h0, 1, 0);
    access(1, 6, 16'h0FFF, 1, 0);
    chk("R8 sticky", {31'd0, rp_err}, 32'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule